// File: doc/BRIEF.md
# Reed-Solomon Packet Output Flag Generator

This block sits on the byte-wide output of a Reed-Solomon decoder and labels every byte that leaves it. Packets have a fixed structure: one sync byte, then the payload, then sixteen parity bytes. The parity bytes are always present, even when encoding is switched off. The packet length depends on where the sync byte comes from. When the sync byte is supplied from outside, a packet is 240 bytes with 223 payload bytes. When the sync byte is inserted internally, a packet is 255 bytes with 238 payload bytes.

Bytes move only on cycles where the byte enable is high, which stands in for the gated byte clock. Sync and parity bytes count as bytes like any other. For each enabled byte the block registers the data together with three flags:
- a sync flag, high on the first byte of a packet;
- a valid flag, high only on payload bytes;
- a good flag, telling the consumer that the decoder found the packet correctable and free of errors.

An upstream start-of-packet strobe realigns the position count at any time. The mode input and the good indication are each captured once per packet, on its first byte.

Top module: `rs_pkt_flag_gen`

## Requirements
- R1: After reset every output is 0, and the first enabled byte after reset is taken as position 0 (sync).
- R2: The sync flag is 1 only on the output of a position-0 byte, and never at the same time as the valid flag.
- R3: The valid flag is 1 on payload positions 1..P. It is 0 on position 0 and on the 16 parity positions P+1..P+16.
- R4: With the mode input at 1 (sync byte supplied externally), P is 223 and a packet spans 240 enabled bytes.
- R5: With the mode input at 0 (sync byte inserted internally), P is 238 and a packet spans 255 enabled bytes.
- R6: The byte strobe output equals the byte enable delayed by one clock. On cycles without an enable, the data and all flags hold their previous values and the position does not advance.
- R7: An enabled byte that arrives with the start-of-packet strobe is placed at position 0, whatever the current count.
- R8: The good flag for every byte of a packet equals the good indication sampled with that packet's position-0 byte. Changes of the indication later in the packet have no effect.
- R9: The mode input is sampled on the position-0 byte. A mode change in mid-packet does not alter the current packet's length or payload span.
- R10: The output data equals the input data of the enabled byte, one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| byte_en_i | input | 1 | Byte enable; a byte is present on this cycle |
| sop_i | input | 1 | Start-of-packet strobe, qualified by byte_en_i |
| ext_sync_i | input | 1 | 1 = external sync (240-byte packet), 0 = internal sync (255-byte packet) |
| pkt_ok_i | input | 1 | Decoder reports the packet correctable with no errors |
| din_i | input | DATA_W | Decoded byte |
| dout_o | output | DATA_W | Registered byte |
| out_stb_o | output | 1 | A new byte is on dout_o |
| psync_o | output | 1 | Sync byte on the bus |
| dvalid_o | output | 1 | Payload byte on the bus |
| pgood_o | output | 1 | Current packet is error free |

## Verification
The stimulus combines several patterns:
- Gap-free runs of two whole packets in each mode. These separate the 240/223 framing from the 255/238 framing by counting the bytes between sync flags and the valid and parity bytes inside a packet.
- Runs with enable gaps. These show whether idle cycles advance the position or disturb the held flags.
- Start-of-packet strobes in mid-packet, which expose a counter that ignores realignment.
- Random toggling of the mode and good inputs inside packets, which separates sampling on the first byte from sampling on every byte.

// File: rtl/rs_flag_pkg.sv
package rs_flag_pkg;
   typedef enum logic [1:0] {
      BK_SYNC   = 2'd0,
      BK_DATA   = 2'd1,
      BK_PARITY = 2'd2
   } byte_kind_e;

   function automatic int unsigned pkt_len(input int unsigned pay, input int unsigned par);
      return 1 + pay + par;
   endfunction
endpackage

// File: rtl/rs_pkt_pos_ctr.sv
module rs_pkt_pos_ctr #(
   parameter int unsigned PAY_EXT = 223,
   parameter int unsigned PAY_INT = 238,
   parameter int unsigned PAR_N   = 16,
   parameter int unsigned POS_W   = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv_i,
   input  logic             sop_i,
   input  logic             ext_sync_i,
   output logic [POS_W-1:0] pos_o,
   output logic             mode_o,
   output logic             first_o
);
   import rs_flag_pkg::*;

   localparam int unsigned LEN_EXT = pkt_len(PAY_EXT, PAR_N);
   localparam int unsigned LEN_INT = pkt_len(PAY_INT, PAR_N);
   localparam logic [POS_W-1:0] LAST_EXT = POS_W'(LEN_EXT - 1);
   localparam logic [POS_W-1:0] LAST_INT = POS_W'(LEN_INT - 1);

   generate
      if ((LEN_EXT > (1 << POS_W)) || (LEN_INT > (1 << POS_W))) begin : g_bad_w
         $error("rs_pkt_pos_ctr: POS_W too small for packet length");
      end
   endgenerate

   logic [POS_W-1:0] cnt_q;
   logic             mode_q;
   logic [POS_W-1:0] last;

   always_comb begin
      pos_o   = sop_i ? '0 : cnt_q;
      first_o = (pos_o == '0);
      mode_o  = first_o ? ext_sync_i : mode_q;
      last    = mode_o ? LAST_EXT : LAST_INT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         mode_q <= 1'b0;
      end else if (adv_i) begin
         cnt_q <= (pos_o == last) ? '0 : pos_o + 1'b1;
         if (first_o) mode_q <= ext_sync_i;
      end
   end
endmodule

// File: rtl/rs_pkt_classify.sv
module rs_pkt_classify #(
   parameter int unsigned PAY_EXT = 223,
   parameter int unsigned PAY_INT = 238,
   parameter int unsigned POS_W   = 8
) (
   input  logic                      [POS_W-1:0] pos_i,
   input  logic                                  mode_i,
   output rs_flag_pkg::byte_kind_e               kind_o
);
   import rs_flag_pkg::*;

   localparam logic [POS_W-1:0] PEND_EXT = POS_W'(PAY_EXT);
   localparam logic [POS_W-1:0] PEND_INT = POS_W'(PAY_INT);

   logic [POS_W-1:0] pay_end;

   always_comb begin
      pay_end = mode_i ? PEND_EXT : PEND_INT;
      if (pos_i == '0)          kind_o = BK_SYNC;
      else if (pos_i <= pay_end) kind_o = BK_DATA;
      else                       kind_o = BK_PARITY;
   end
endmodule

// File: rtl/rs_pkt_good_hold.sv
module rs_pkt_good_hold (
   input  logic clk,
   input  logic rst_n,
   input  logic adv_i,
   input  logic first_i,
   input  logic ok_i,
   output logic good_o
);
   logic good_q;

   assign good_o = first_i ? ok_i : good_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 good_q <= 1'b0;
      else if (adv_i && first_i)  good_q <= ok_i;
   end
endmodule

// File: rtl/rs_pkt_flag_gen.sv
module rs_pkt_flag_gen #(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned PAY_EXT = 223,
   parameter int unsigned PAY_INT = 238,
   parameter int unsigned PAR_N   = 16,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_en_i,
   input  logic              sop_i,
   input  logic              ext_sync_i,
   input  logic              pkt_ok_i,
   input  logic [DATA_W-1:0] din_i,
   output logic [DATA_W-1:0] dout_o,
   output logic              out_stb_o,
   output logic              psync_o,
   output logic              dvalid_o,
   output logic              pgood_o
);
   import rs_flag_pkg::*;

   localparam int unsigned LEN_MAX = (PAY_EXT > PAY_INT) ? pkt_len(PAY_EXT, PAR_N)
                                                          : pkt_len(PAY_INT, PAR_N);
   localparam int unsigned POS_W = $clog2(LEN_MAX);

   generate
      if (DATA_W == 0) begin : g_bad_dw
         $error("rs_pkt_flag_gen: DATA_W must be nonzero");
      end
      if (PAR_N == 0) begin : g_bad_par
         $error("rs_pkt_flag_gen: PAR_N must be nonzero");
      end
   endgenerate

   logic [POS_W-1:0] pos;
   logic             mode_eff;
   logic             first;
   logic             good;
   byte_kind_e       kind;

   rs_pkt_pos_ctr #(
      .PAY_EXT(PAY_EXT), .PAY_INT(PAY_INT), .PAR_N(PAR_N), .POS_W(POS_W)
   ) u_ctr (
      .clk(clk), .rst_n(rst_n), .adv_i(byte_en_i), .sop_i(sop_i),
      .ext_sync_i(ext_sync_i), .pos_o(pos), .mode_o(mode_eff), .first_o(first)
   );

   rs_pkt_classify #(
      .PAY_EXT(PAY_EXT), .PAY_INT(PAY_INT), .POS_W(POS_W)
   ) u_cls (
      .pos_i(pos), .mode_i(mode_eff), .kind_o(kind)
   );

   rs_pkt_good_hold u_good (
      .clk(clk), .rst_n(rst_n), .adv_i(byte_en_i), .first_i(first),
      .ok_i(pkt_ok_i), .good_o(good)
   );

   logic ps_n, dv_n, pg_n;
   assign ps_n = (kind == BK_SYNC);
   assign dv_n = (kind == BK_DATA);
   assign pg_n = good;

   generate
      if (OUT_REG) begin : g_reg
         logic [DATA_W-1:0] d_q;
         logic              stb_q, ps_q, dv_q, pg_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               d_q   <= '0;
               stb_q <= 1'b0;
               ps_q  <= 1'b0;
               dv_q  <= 1'b0;
               pg_q  <= 1'b0;
            end else begin
               stb_q <= byte_en_i;
               if (byte_en_i) begin
                  d_q  <= din_i;
                  ps_q <= ps_n;
                  dv_q <= dv_n;
                  pg_q <= pg_n;
               end
            end
         end
         assign dout_o    = d_q;
         assign out_stb_o = stb_q;
         assign psync_o   = ps_q;
         assign dvalid_o  = dv_q;
         assign pgood_o   = pg_q;
      end else begin : g_comb
         assign dout_o    = din_i;
         assign out_stb_o = byte_en_i;
         assign psync_o   = byte_en_i & ps_n;
         assign dvalid_o  = byte_en_i & dv_n;
         assign pgood_o   = byte_en_i & pg_n;
      end
   endgenerate
endmodule

// File: rtl/rs_pkt_flag_chk.sv
module rs_pkt_flag_chk #(
   parameter int unsigned DATA_W  = 8,
   parameter bit          OUT_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              byte_en_i,
   input logic              sop_i,
   input logic [DATA_W-1:0] din_i,
   input logic [DATA_W-1:0] dout_o,
   input logic              out_stb_o,
   input logic              psync_o,
   input logic              dvalid_o,
   input logic              pgood_o
);
   generate
      if (OUT_REG) begin : g_props
         // R2
         sync_not_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(psync_o && dvalid_o));
         // R6
         stb_follows_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
            byte_en_i |=> out_stb_o);
         // R6
         idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !byte_en_i |=> (!out_stb_o && $stable(dout_o) && $stable(psync_o)
                            && $stable(dvalid_o) && $stable(pgood_o)));
         // R7
         sop_realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (byte_en_i && sop_i) |=> psync_o);
         // R8
         good_only_at_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(pgood_o) |-> psync_o);
         // R10
         data_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            byte_en_i |=> (dout_o == $past(din_i)));
      end else begin : g_props_comb
         // R2
         sync_not_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(psync_o && dvalid_o));
         // R7
         sop_realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (byte_en_i && sop_i) |-> psync_o);
         // R10
         data_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            dout_o == din_i);
         // R6
         stb_follows_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_stb_o == byte_en_i);
      end
   endgenerate
endmodule

bind rs_pkt_flag_gen rs_pkt_flag_chk #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_chk (
   .clk(clk), .rst_n(rst_n), .byte_en_i(byte_en_i), .sop_i(sop_i), .din_i(din_i),
   .dout_o(dout_o), .out_stb_o(out_stb_o), .psync_o(psync_o),
   .dvalid_o(dvalid_o), .pgood_o(pgood_o)
);

// File: tb/rs_pkt_flag_gen_tb.sv
module rs_pkt_flag_gen_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       byte_en_i = 1'b0, sop_i = 1'b0, ext_sync_i = 1'b0, pkt_ok_i = 1'b0;
   logic [7:0] din_i = '0;
   logic [7:0] dout_o;
   logic       out_stb_o, psync_o, dvalid_o, pgood_o;

   always #2 clk = ~clk;

   rs_pkt_flag_gen u_dut (
      .clk(clk), .rst_n(rst_n), .byte_en_i(byte_en_i), .sop_i(sop_i),
      .ext_sync_i(ext_sync_i), .pkt_ok_i(pkt_ok_i), .din_i(din_i),
      .dout_o(dout_o), .out_stb_o(out_stb_o), .psync_o(psync_o),
      .dvalid_o(dvalid_o), .pgood_o(pgood_o)
   );

   int errs = 0, checks = 0;
   bit done = 1'b0;

   // reference model state
   int m_pos = 0;
   bit m_mode = 1'b0, m_good = 1'b0;
   bit e_stb = 0, e_ps = 0, e_dv = 0, e_pg = 0;
   logic [7:0] e_d = '0;

   // framing measurement from outputs
   int gap = 0, dv_cnt = 0, par_cnt = 0;
   int last_gap = -1, last_dv = -1, last_par = -1;
   bit seen_sync = 0;

   function automatic int pay_of(input bit mode);
      return mode ? 223 : 238;
   endfunction
   function automatic int len_of(input bit mode);
      return pay_of(mode) + 17;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(input bit en, input bit sop, input bit ok, input bit mode,
                      input logic [7:0] d);
      int p;
      byte_en_i = en; sop_i = sop; pkt_ok_i = ok; ext_sync_i = mode; din_i = d;
      if (en) begin
         p = sop ? 0 : m_pos;
         if (p == 0) begin m_mode = mode; m_good = ok; end
         e_ps = (p == 0);
         e_dv = (p >= 1) && (p <= pay_of(m_mode));
         e_pg = m_good;
         e_d  = d;
         m_pos = (p == len_of(m_mode) - 1) ? 0 : p + 1;
      end
      e_stb = en;
      @(posedge clk); #1;
      chk(out_stb_o == e_stb, "R6 strobe", out_stb_o, e_stb);
      chk(psync_o == e_ps, "R2 sync flag", psync_o, e_ps);
      chk(dvalid_o == e_dv, "R3 valid flag", dvalid_o, e_dv);
      chk(pgood_o == e_pg, "R8 good flag", pgood_o, e_pg);
      chk(dout_o == e_d, "R10 data", dout_o, e_d);
      if (out_stb_o) begin
         if (psync_o) begin
            if (seen_sync) begin last_gap = gap; last_dv = dv_cnt; last_par = par_cnt; end
            seen_sync = 1; gap = 0; dv_cnt = 0; par_cnt = 0;
         end else if (dvalid_o) dv_cnt++;
         else par_cnt++;
         gap++;
      end
      @(negedge clk);
   endtask

   task automatic reset_dut();
      rst_n = 1'b0;
      byte_en_i = 0; sop_i = 0;
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      m_pos = 0; m_mode = 0; m_good = 0;
      e_stb = 0; e_ps = 0; e_dv = 0; e_pg = 0; e_d = '0;
      seen_sync = 0; gap = 0; last_gap = -1;
      @(negedge clk);
   endtask

   task automatic run_frame_check(input bit mode, input string req);
      reset_dut();
      for (int i = 0; i < 2 * len_of(mode) + 1; i++) cyc(1, 0, 1, mode, 8'(i));
      chk(last_gap == len_of(mode), {req, " packet length"}, last_gap, len_of(mode));
      chk(last_dv == pay_of(mode), {req, " payload count"}, last_dv, pay_of(mode));
      chk(last_par == 16, {req, " parity count"}, last_par, 16);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         errs++; checks++;
         $display("FAIL watchdog expired");
         $display("  Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      @(negedge clk);
      // R1: reset state
      chk({dout_o, out_stb_o, psync_o, dvalid_o, pgood_o} == '0, "R1 reset outputs",
          {dout_o, out_stb_o, psync_o, dvalid_o, pgood_o}, 0);
      reset_dut();
      cyc(1, 0, 1, 1, 8'hA5);
      chk(psync_o == 1, "R1 first byte is sync", psync_o, 1);

      // R4 / R5 framing, gap-free
      run_frame_check(1'b1, "R4");
      run_frame_check(1'b0, "R5");

      // R7: mid-packet realignment
      reset_dut();
      for (int i = 0; i < 50; i++) cyc(1, 0, 0, 1, 8'(i));
      cyc(1, 1, 1, 1, 8'h3C);
      chk(psync_o == 1, "R7 sop realign", psync_o, 1);

      // R8 / R9: inputs toggled mid-packet have no effect
      reset_dut();
      cyc(1, 0, 1, 1, 8'h01);
      for (int i = 1; i < 240; i++) cyc(1, 0, i[0], ~i[1], 8'(i));
      cyc(1, 0, 0, 1, 8'h77);
      chk(psync_o == 1, "R9 length kept after mode toggles", psync_o, 1);

      // R6: idle gaps plus random traffic
      reset_dut();
      for (int i = 0; i < 6000; i++) begin
         bit en, sop, ok, md;
         en  = ($urandom % 10) < 7;
         sop = ($urandom % 400) == 0;
         ok  = $urandom % 2;
         md  = ($urandom % 8) != 0 ? m_mode : ~m_mode;
         cyc(en, sop, ok, md, 8'($urandom));
      end

      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule